// File: doc/BRIEF.md
# Cursor Clip and Frame-Synchronous Latch

This block takes a cursor placement request (a signed x/y position, a requested width and height, and whether a cursor image exists) and clips it against the active display area. It produces the visible width and height, the on-screen start position, the starting word index inside the cursor bitmap, and the bitmap line stride. When the display scans interlaced fields, the vertical results are halved and the stride is doubled.

Clipped results do not reach the live cursor registers at once. They are held as a pending update. On the next frame-done pulse they are copied into the live position and size registers, and the cursor enable is set in the same cycle. A request that leaves nothing visible clears the enable immediately and drops any pending update. A request whose visible size differs from the last one clears the enable immediately and asks for an image reload. A request whose size is outside the supported range is refused.

Requests arrive on a valid/ready port. The block never applies back-pressure: `req_ready` is held high and every request is taken in the cycle it is presented. The display geometry, the interlace flag and the frame-done pulse are plain inputs.

Top module: `cursor_clip_latch`

## Requirements
- R1: A negative x gives a bitmap x offset of -x and a screen x of 0, and the visible width is the requested width minus that offset, saturating at 0. The y axis behaves the same way.
- R2: When position plus size exceeds the display extent on an axis, the visible size on that axis is the extent minus the position, floored at 0. The screen position is the requested position.
- R3: A cursor lying fully inside the display (position plus size not greater than the extent) keeps its requested size, its position and a zero bitmap offset.
- R4: With `interlaced` high, the screen y and the visible height (after clipping) are halved and the stride is twice the requested width; otherwise the stride equals the requested width. `img_start` = y offset * stride + x offset.
- R5: An accepted request with zero visible width, zero visible height (after interlace halving) or `req_img` low clears `cur_en` and `pending` in the next cycle. A cancelled update never reaches the live registers.
- R6: `live_pos` is {screen y[31:16], screen x[15:0]} and `live_size` is {visible height[31:16], visible width[15:0]}. Both change only on a `frame_done` pulse while `pending` is high. That pulse also sets `cur_en` and clears `pending`.
- R7: An accepted visible request whose packed size differs from the previous visible request clears `cur_en` in the next cycle and pulses `reload` high for exactly one cycle.
- R8: An accepted visible request with the same packed size as the previous one leaves `cur_en` unchanged and does not pulse `reload`.
- R9: A request with width or height above 64, or with both above 32, pulses `size_err` for one cycle and leaves `cur_en`, `pending` and the live registers unchanged.
- R10: `req_ready` is always high. An accepted request sets `pending` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cursor request present |
| req_ready | output | 1 | Always high; the block takes every request |
| req_x | input | 16 | Signed cursor x |
| req_y | input | 16 | Signed cursor y |
| req_w | input | 8 | Requested cursor width |
| req_h | input | 8 | Requested cursor height |
| req_img | input | 1 | A cursor image exists |
| disp_w | input | 16 | Active display width |
| disp_h | input | 16 | Active display height (per field when interlaced) |
| interlaced | input | 1 | Interlaced scan |
| frame_done | input | 1 | End-of-frame pulse |
| live_pos | output | 32 | Live packed position |
| live_size | output | 32 | Live packed visible size |
| cur_en | output | 1 | Cursor enable |
| pending | output | 1 | An update is waiting for frame-done |
| reload | output | 1 | One-cycle request to reload the image |
| img_start | output | 26 | Bitmap start word index of the pending update |
| img_stride | output | 9 | Bitmap line stride of the pending update |
| size_err | output | 1 | One-cycle out-of-range size flag |

## Verification
Every cycle, the assertions check that the visible size never exceeds the requested size. They also check that the frame-done transfer copies the pending values and raises the enable, that the enable rises only after a frame-done pulse, and that refused, empty and resized requests act on the enable and pending state as required. The exact clip arithmetic at each screen edge, the interlace halving and the bitmap start index are shown only by the bench's vectors. The same holds for the fact that a cancelled update never reaches the live registers and for the one-cycle length of the reload and error pulses.

// File: rtl/cclip_pkg.sv
package cclip_pkg;
  localparam int unsigned DEF_POS_W  = 16;
  localparam int unsigned DEF_SZ_W   = 8;
  localparam int unsigned DEF_MAX    = 64;
  localparam int unsigned DEF_NARROW = 32;

  typedef enum logic [1:0] {
    AX_INSIDE    = 2'd0,
    AX_LOW_CLIP  = 2'd1,
    AX_HIGH_CLIP = 2'd2
  } axis_case_e;
endpackage

// File: rtl/cclip_axis.sv
module cclip_axis
  import cclip_pkg::*;
#(
  parameter int unsigned POS_W = DEF_POS_W,
  parameter int unsigned SZ_W  = DEF_SZ_W
) (
  input  logic signed [POS_W-1:0] pos,
  input  logic        [SZ_W-1:0]  size,
  input  logic        [POS_W-1:0] limit,
  output logic        [POS_W-1:0] scr,
  output logic        [POS_W-1:0] off,
  output logic        [SZ_W-1:0]  vis,
  output axis_case_e              kind
);
  localparam int unsigned EW = POS_W + 2;

  logic signed [EW-1:0] p_e, lim_e, sz_e, neg_e, end_e, room_e;

  always_comb begin
    p_e    = {{2{pos[POS_W-1]}}, pos};
    lim_e  = {2'b00, limit};
    sz_e   = {{(EW-SZ_W){1'b0}}, size};
    neg_e  = -p_e;
    end_e  = p_e + sz_e;
    room_e = lim_e - p_e;
    scr    = '0;
    off    = '0;
    vis    = size;
    kind   = AX_INSIDE;
    if (p_e < 0) begin
      kind = AX_LOW_CLIP;
      off  = neg_e[POS_W-1:0];
      vis  = (neg_e >= sz_e) ? '0 : size - neg_e[SZ_W-1:0];
    end else if (end_e > lim_e) begin
      kind = AX_HIGH_CLIP;
      scr  = pos;
      vis  = (room_e <= 0) ? '0 : room_e[SZ_W-1:0];
    end else begin
      scr  = pos;
    end
  end
endmodule

// File: rtl/cclip_range.sv
module cclip_range
  import cclip_pkg::*;
#(
  parameter int unsigned SZ_W   = DEF_SZ_W,
  parameter int unsigned MAXD   = DEF_MAX,
  parameter int unsigned NARROW = DEF_NARROW
) (
  input  logic [SZ_W-1:0] w,
  input  logic [SZ_W-1:0] h,
  output logic            bad
);
  localparam logic [SZ_W-1:0] MAX_V = SZ_W'(MAXD);
  localparam logic [SZ_W-1:0] NAR_V = SZ_W'(NARROW);

  always_comb begin
    bad = (w > MAX_V) || (h > MAX_V) || ((w > NAR_V) && (h > NAR_V));
  end
endmodule

// File: rtl/cclip_latch.sv
module cclip_latch #(
  parameter int unsigned PW  = 32,
  parameter int unsigned STW = 26,
  parameter int unsigned RW  = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic           bad,
  input  logic           empty,
  input  logic [PW-1:0]  new_pos,
  input  logic [PW-1:0]  new_size,
  input  logic [STW-1:0] new_start,
  input  logic [RW-1:0]  new_stride,
  input  logic           frame_done,
  output logic [PW-1:0]  live_pos,
  output logic [PW-1:0]  live_size,
  output logic           cur_en,
  output logic           pending,
  output logic           reload,
  output logic           size_err,
  output logic [STW-1:0] img_start,
  output logic [RW-1:0]  img_stride
);
  logic [PW-1:0] pend_pos, pend_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_pos   <= '0;
      pend_size  <= '0;
      live_pos   <= '0;
      live_size  <= '0;
      cur_en     <= 1'b0;
      pending    <= 1'b0;
      reload     <= 1'b0;
      size_err   <= 1'b0;
      img_start  <= '0;
      img_stride <= '0;
    end else begin
      reload   <= 1'b0;
      size_err <= 1'b0;
      if (frame_done && pending) begin
        live_pos  <= pend_pos;
        live_size <= pend_size;
        cur_en    <= 1'b1;
        pending   <= 1'b0;
      end
      if (acc) begin
        if (bad) begin
          size_err <= 1'b1;
        end else if (empty) begin
          cur_en  <= 1'b0;
          pending <= 1'b0;
        end else begin
          if (new_size != pend_size) begin
            cur_en <= 1'b0;
            reload <= 1'b1;
          end
          pend_pos   <= new_pos;
          pend_size  <= new_size;
          img_start  <= new_start;
          img_stride <= new_stride;
          pending    <= 1'b1;
        end
      end
    end
  end

  // R6: frame-done copies the pending update and enables the cursor
  a_r6_frame_copy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && pending && !acc |=> cur_en && !pending &&
      live_pos == $past(pend_pos) && live_size == $past(pend_size));

  // R6: the enable only rises after a frame-done pulse
  a_r6_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_en) |-> $past(frame_done));

  // R9: a refused request leaves the state alone
  a_r9_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad && !frame_done |=> size_err && $stable(cur_en) &&
      $stable(pending) && $stable(live_pos) && $stable(live_size));

  // R5: an empty request disables at once
  a_r5_empty_off: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bad && empty |=> !cur_en && !pending);

  // R7: a new visible size disables and requests reload
  a_r7_resize: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bad && !empty && new_size != pend_size |=> !cur_en && reload && pending);
endmodule

// File: rtl/cursor_clip_latch.sv
module cursor_clip_latch
  import cclip_pkg::*;
#(
  parameter int unsigned POS_W  = DEF_POS_W,
  parameter int unsigned SZ_W   = DEF_SZ_W,
  parameter int unsigned MAXD   = DEF_MAX,
  parameter int unsigned NARROW = DEF_NARROW,
  localparam int unsigned PW    = 2 * POS_W,
  localparam int unsigned RW    = SZ_W + 1,
  localparam int unsigned STW   = POS_W + SZ_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic signed [POS_W-1:0] req_x,
  input  logic signed [POS_W-1:0] req_y,
  input  logic        [SZ_W-1:0]  req_w,
  input  logic        [SZ_W-1:0]  req_h,
  input  logic                    req_img,
  input  logic        [POS_W-1:0] disp_w,
  input  logic        [POS_W-1:0] disp_h,
  input  logic                    interlaced,
  input  logic                    frame_done,
  output logic        [PW-1:0]    live_pos,
  output logic        [PW-1:0]    live_size,
  output logic                    cur_en,
  output logic                    pending,
  output logic                    reload,
  output logic        [STW-1:0]   img_start,
  output logic        [RW-1:0]    img_stride,
  output logic                    size_err
);
  logic [POS_W-1:0] scr_x, scr_y, off_x, off_y, scr_y_f;
  logic [SZ_W-1:0]  vis_w, vis_h, vis_h_f;
  logic [RW-1:0]    stride;
  logic [STW-1:0]   start;
  logic [PW-1:0]    pos_pk, size_pk;
  logic             bad, empty, acc;
  axis_case_e       kind_x, kind_y;

  assign req_ready = 1'b1;
  assign acc       = req_valid & req_ready;

  cclip_axis #(.POS_W(POS_W), .SZ_W(SZ_W)) u_ax_x (
    .pos(req_x), .size(req_w), .limit(disp_w),
    .scr(scr_x), .off(off_x), .vis(vis_w), .kind(kind_x));

  cclip_axis #(.POS_W(POS_W), .SZ_W(SZ_W)) u_ax_y (
    .pos(req_y), .size(req_h), .limit(disp_h),
    .scr(scr_y), .off(off_y), .vis(vis_h), .kind(kind_y));

  cclip_range #(.SZ_W(SZ_W), .MAXD(MAXD), .NARROW(NARROW)) u_range (
    .w(req_w), .h(req_h), .bad(bad));

  always_comb begin
    scr_y_f = interlaced ? (scr_y >> 1) : scr_y;
    vis_h_f = interlaced ? (vis_h >> 1) : vis_h;
    stride  = interlaced ? {req_w, 1'b0} : {1'b0, req_w};
    start   = STW'(off_y) * STW'(stride) + STW'(off_x);
    empty   = !req_img || (vis_w == '0) || (vis_h_f == '0);
    pos_pk  = {scr_y_f, scr_x};
    size_pk = {{(POS_W-SZ_W){1'b0}}, vis_h_f, {(POS_W-SZ_W){1'b0}}, vis_w};
  end

  cclip_latch #(.PW(PW), .STW(STW), .RW(RW)) u_latch (
    .clk(clk), .rst_n(rst_n), .acc(acc), .bad(bad), .empty(empty),
    .new_pos(pos_pk), .new_size(size_pk), .new_start(start), .new_stride(stride),
    .frame_done(frame_done), .live_pos(live_pos), .live_size(live_size),
    .cur_en(cur_en), .pending(pending), .reload(reload), .size_err(size_err),
    .img_start(img_start), .img_stride(img_stride));

  // R1 R2 R3: clipping never enlarges the cursor
  a_r3_vis_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> vis_w <= req_w && vis_h <= req_h);

  // R1: a low-edge clip always places the cursor at screen 0
  a_r1_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && kind_x == AX_LOW_CLIP |-> scr_x == '0);

  // R10: an accepted good visible request becomes pending
  a_r10_pending: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bad && !empty |=> pending);

  // R2: a high-edge clip keeps the requested y and no offset
  a_r2_high_edge: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && kind_y == AX_HIGH_CLIP |-> off_y == '0 && scr_y == req_y);
endmodule

// File: tb/sim_cursor_clip_latch.sv
module sim_cursor_clip_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic               req_valid = 1'b0, req_img = 1'b1, interlaced = 1'b0, frame_done = 1'b0;
  logic signed [15:0] req_x = '0, req_y = '0;
  logic [7:0]         req_w = '0, req_h = '0;
  logic [15:0]        disp_w = 16'd640, disp_h = 16'd480;
  logic               req_ready, cur_en, pending, reload, size_err;
  logic [31:0]        live_pos, live_size;
  logic [25:0]        img_start;
  logic [8:0]         img_stride;

  cursor_clip_latch u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h), .req_img(req_img),
    .disp_w(disp_w), .disp_h(disp_h), .interlaced(interlaced), .frame_done(frame_done),
    .live_pos(live_pos), .live_size(live_size), .cur_en(cur_en), .pending(pending),
    .reload(reload), .img_start(img_start), .img_stride(img_stride), .size_err(size_err));

  typedef struct packed {
    logic signed [15:0] x;
    logic signed [15:0] y;
    logic [7:0]  w;
    logic [7:0]  h;
    logic        il;
    logic [31:0] pos;
    logic [31:0] size;
    logic [31:0] start;
    logic [8:0]  stride;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{16'sd100,  16'sd50,  8'd32, 8'd32, 1'b0, 32'h0032_0064, 32'h0020_0020, 32'd0,   9'd32},
    '{-16'sd10,  16'sd20,  8'd32, 8'd64, 1'b0, 32'h0014_0000, 32'h0040_0016, 32'd10,  9'd32},
    '{16'sd5,    -16'sd7,  8'd64, 8'd32, 1'b0, 32'h0000_0005, 32'h0019_0040, 32'd448, 9'd64},
    '{16'sd620,  16'sd470, 8'd32, 8'd32, 1'b0, 32'h01D6_026C, 32'h000A_0014, 32'd0,   9'd32},
    '{16'sd200,  16'sd101, 8'd16, 8'd48, 1'b1, 32'h0032_00C8, 32'h0018_0010, 32'd0,   9'd32},
    '{-16'sd4,   -16'sd6,  8'd32, 8'd32, 1'b1, 32'h0000_0000, 32'h000D_001C, 32'd388, 9'd64},
    '{16'sd0,    16'sd0,   8'd64, 8'd32, 1'b0, 32'h0000_0000, 32'h0020_0040, 32'd0,   9'd64},
    '{16'sd608,  16'sd448, 8'd32, 8'd32, 1'b0, 32'h01C0_0260, 32'h0020_0020, 32'd0,   9'd32}
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input logic signed [15:0] x, input logic signed [15:0] y,
                         input logic [7:0] w, input logic [7:0] h, input logic img, input logic il);
    @(negedge clk);
    req_x = x; req_y = y; req_w = w; req_h = h; req_img = img; interlaced = il;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cur_en == 1'b0 && pending == 1'b0, "R6 reset enable/pending", {30'd0, cur_en, pending}, 32'd0);
    chk(live_pos == 32'd0 && live_size == 32'd0, "R6 reset live regs", live_pos | live_size, 32'd0);
    chk(size_err == 1'b0 && reload == 1'b0, "R9 reset flags", {30'd0, size_err, reload}, 32'd0);
    chk(req_ready == 1'b1, "R10 ready in reset", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;

    // table: R1 R2 R3 R4 R6 vectors
    foreach (TBL[i]) begin
      request(TBL[i].x, TBL[i].y, TBL[i].w, TBL[i].h, 1'b1, TBL[i].il);
      chk(pending == 1'b1, $sformatf("R10 pending after vec %0d", i), {31'd0, pending}, 32'd1);
      chk({6'd0, img_start} == TBL[i].start, $sformatf("R1 R4 start vec %0d", i), {6'd0, img_start}, TBL[i].start);
      chk(img_stride == TBL[i].stride, $sformatf("R4 stride vec %0d", i), {23'd0, img_stride}, {23'd0, TBL[i].stride});
      frame();
      chk(live_pos == TBL[i].pos, $sformatf("R6 R2 pos vec %0d", i), live_pos, TBL[i].pos);
      chk(live_size == TBL[i].size, $sformatf("R3 R1 size vec %0d", i), live_size, TBL[i].size);
      chk(cur_en == 1'b1 && pending == 1'b0, $sformatf("R6 enable vec %0d", i), {30'd0, cur_en, pending}, 32'd2);
    end

    // R8 same size, R6 deferral
    request(16'sd10, 16'sd10, 8'd32, 8'd32, 1'b1, 1'b0);
    chk(cur_en == 1'b1 && reload == 1'b0, "R8 same size keeps enable", {30'd0, cur_en, reload}, 32'd2);
    chk(live_pos == 32'h01C0_0260, "R6 live held before frame", live_pos, 32'h01C0_0260);
    frame();
    chk(live_pos == 32'h000A_000A, "R6 live after frame", live_pos, 32'h000A_000A);

    // R7 resize
    request(16'sd10, 16'sd10, 8'd16, 8'd16, 1'b1, 1'b0);
    chk(cur_en == 1'b0 && reload == 1'b1, "R7 resize disables and reloads", {30'd0, cur_en, reload}, 32'd1);
    @(negedge clk);
    chk(reload == 1'b0, "R7 reload one cycle", {31'd0, reload}, 32'd0);
    frame();
    chk(cur_en == 1'b1 && live_size == 32'h0010_0010, "R7 re-enabled at frame", live_size, 32'h0010_0010);

    // R9 out of range
    request(16'sd0, 16'sd0, 8'd65, 8'd16, 1'b1, 1'b0);
    chk(size_err == 1'b1 && cur_en == 1'b1 && pending == 1'b0, "R9 width 65 refused",
        {29'd0, size_err, cur_en, pending}, 32'd6);
    @(negedge clk);
    chk(size_err == 1'b0, "R9 error one cycle", {31'd0, size_err}, 32'd0);
    request(16'sd0, 16'sd0, 8'd40, 8'd40, 1'b1, 1'b0);
    chk(size_err == 1'b1 && pending == 1'b0, "R9 both above 32 refused", {30'd0, size_err, pending}, 32'd2);
    frame();
    chk(live_pos == 32'h000A_000A && live_size == 32'h0010_0010, "R9 live unchanged", live_pos, 32'h000A_000A);

    // R5 cancel by off-screen request
    request(16'sd20, 16'sd20, 8'd16, 8'd16, 1'b1, 1'b0);
    chk(pending == 1'b1, "R5 setup pending", {31'd0, pending}, 32'd1);
    request(16'sd700, 16'sd0, 8'd16, 8'd16, 1'b1, 1'b0);
    chk(cur_en == 1'b0 && pending == 1'b0, "R5 zero width disables", {30'd0, cur_en, pending}, 32'd0);
    frame();
    chk(live_pos == 32'h000A_000A && cur_en == 1'b0, "R5 cancelled update not applied", live_pos, 32'h000A_000A);

    // R5 no image
    request(16'sd5, 16'sd5, 8'd16, 8'd16, 1'b1, 1'b0);
    frame();
    chk(cur_en == 1'b1, "R5 setup enable", {31'd0, cur_en}, 32'd1);
    request(16'sd5, 16'sd5, 8'd16, 8'd16, 1'b0, 1'b0);
    chk(cur_en == 1'b0 && pending == 1'b0, "R5 no image disables", {30'd0, cur_en, pending}, 32'd0);

    // R4 interlace halving to zero height
    request(16'sd5, 16'sd5, 8'd16, 8'd16, 1'b1, 1'b0);
    request(16'sd5, 16'sd5, 8'd16, 8'd1, 1'b1, 1'b1);
    chk(pending == 1'b0 && cur_en == 1'b0, "R4 R5 halved height empty", {30'd0, cur_en, pending}, 32'd0);

    // R2 floor at zero on bottom edge
    request(16'sd5, 16'sd500, 8'd16, 8'd16, 1'b1, 1'b0);
    chk(pending == 1'b0 && cur_en == 1'b0, "R2 below screen empty", {30'd0, cur_en, pending}, 32'd0);
    chk(req_ready == 1'b1, "R10 ready while running", {31'd0, req_ready}, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule